// File: doc/BRIEF.md
# Reconfigurable Binary-Field Serial-Pair Multiplier

This block computes the product of two polynomials over GF(2) of degree below N and reduces it modulo a field polynomial of degree N that is chosen at run time. The leading term x^N of the field polynomial is implied. The low N coefficients come in on a parallel input and are captured together with the parallel operand when an operation starts. A new field polynomial can therefore be used for every operation without any change to the hardware.

The second operand enters serially to save pins. Its coefficients arrive highest degree first, two per clock cycle, on every cycle where the valid input is high. After ceil(N/2) accepted pairs the reduced product is held on the parallel result output and a one-cycle done strobe is raised. Internally, each coefficient step doubles the accumulator, folds the bit that leaves position N-1 back in through the field polynomial, and adds the parallel operand when the serial coefficient is set. Two such steps are chained within each cycle.

Top module: `gf_serial_mul`

## Requirements
- R1: While reset is asserted, busy_o, done_o and result_o are all zero.
- R2: When start_i is high and busy_o is low at a clock edge, the block captures a_i and mod_i, clears the accumulator, and busy_o is high after that edge.
- R3: Each valid pair carries the higher-degree coefficient in b_pair_i[1] and the next lower one in b_pair_i[0]. Pairs run from the top coefficient down. When done_o rises, result_o equals a*b mod (x^N + mod), where mod bit k is the coefficient of x^k.
- R4: busy_o stays high until exactly ceil(N/2) pairs have been accepted. At the edge that accepts the last pair, busy_o falls and done_o rises.
- R5: When N is odd, the final pair carries coefficient b0 in b_pair_i[1], and b_pair_i[0] in that cycle has no effect on the result.
- R6: done_o is high for one cycle only. After that, result_o holds the product until the next accepted start.
- R7: A start_i pulse while busy_o is high has no effect: the operands captured at the accepted start are still the ones used.
- R8: A cycle with b_valid_i low while busy_o is high leaves the accumulator and the pair count unchanged.
- R9: Changes to a_i or mod_i after the accepted start do not affect the running operation, and each operation uses its own field polynomial.
- R10: b_valid_i while busy_o is low has no effect on result_o or busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle |
| a_i | input | N | Parallel operand, bit k is the coefficient of x^k |
| mod_i | input | N | Field polynomial without its implied x^N term |
| b_valid_i | input | 1 | Marks b_pair_i as valid this cycle |
| b_pair_i | input | 2 | Two serial operand coefficients, higher degree in bit 1 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle strobe when the product is ready |
| result_o | output | N | Reduced product |

## Verification
A wrong accumulator bit or a wrong fold of the overflow bit changes result_o at the done strobe. This shows up ceil(N/2) accepted cycles after start, because every later step carries the error forward. A miscounted pair index shows up earlier, as done_o rising one cycle too soon or too late. Because the field polynomial is varied between operations, a slip in the odd-width pad handling or in the capture of the operands shows as a mismatch in the same cycle as done_o. An odd and an even width are swept side by side to cover both of these paths.

// File: rtl/gf_mul_pkg.sv
package gf_mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/gf_coeff_step.sv
// One Horner step: acc*x mod f, then add a when the coefficient is set.
module gf_coeff_step #(
  parameter int N = 8
) (
  input  logic [N-1:0] acc_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] mod_i,
  input  logic         coef_i,
  output logic [N-1:0] acc_o
);
  logic [N-1:0] shifted;
  logic [N-1:0] folded;

  always_comb begin
    shifted = {acc_i[N-2:0], 1'b0};
    folded  = acc_i[N-1] ? (shifted ^ mod_i) : shifted;
    acc_o   = folded ^ (a_i & {N{coef_i}});
  end
endmodule

// File: rtl/gf_pair_stage.sv
module gf_pair_stage #(
  parameter int N = 8
) (
  input  logic [N-1:0] acc_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] mod_i,
  input  logic [1:0]   pair_i,
  input  logic         single_i,
  output logic [N-1:0] acc_o
);
  localparam int LANES = 2;

  logic [N-1:0] chain [LANES+1];

  assign chain[0] = acc_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    gf_coeff_step #(.N(N)) u_step (
      .acc_i  (chain[l]),
      .a_i    (a_i),
      .mod_i  (mod_i),
      .coef_i (pair_i[LANES-1-l]),
      .acc_o  (chain[l+1])
    );
  end

  // pad slot of an odd-width final cycle is bypassed
  assign acc_o = single_i ? chain[1] : chain[LANES];
endmodule

// File: rtl/gf_seq_ctrl.sv
module gf_seq_ctrl
  import gf_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic b_valid_i,
  output logic load_o,
  output logic step_o,
  output logic single_o,
  output logic busy_o,
  output logic done_o
);
  localparam int PAIRS = (N + 1) / 2;
  localparam int CW    = $clog2(PAIRS + 1);
  localparam bit ODD   = (N % 2) == 1;

  run_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last     = cnt_q == CW'(PAIRS - 1);
  assign busy_o   = state_q == ST_RUN;
  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign step_o   = (state_q == ST_RUN) && b_valid_i;
  assign single_o = ODD && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (step_o) begin
        if (last) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gf_serial_mul.sv
module gf_serial_mul #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] mod_i,
  input  logic         b_valid_i,
  input  logic [1:0]   b_pair_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] result_o
);
  logic [N-1:0] a_q, mod_q, acc_q, acc_nxt;
  logic         load, step, single;

  gf_seq_ctrl #(.N(N)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .b_valid_i (b_valid_i),
    .load_o    (load),
    .step_o    (step),
    .single_o  (single),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  gf_pair_stage #(.N(N)) u_pair (
    .acc_i    (acc_q),
    .a_i      (a_q),
    .mod_i    (mod_q),
    .pair_i   (b_pair_i),
    .single_i (single),
    .acc_o    (acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      mod_q <= '0;
      acc_q <= '0;
    end else if (load) begin
      a_q   <= a_i;
      mod_q <= mod_i;
      acc_q <= '0;
    end else if (step) begin
      acc_q <= acc_nxt;
    end
  end

  assign result_o = acc_q;
endmodule

// File: rtl/gf_serial_mul_chk.sv
module gf_serial_mul_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         b_valid_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [N-1:0] result_o
);
  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) reset_state_chk: assert (!busy_o && !done_o && result_o == '0);
  end

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R4
  done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && $stable(result_o)));

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !b_valid_i) |=> (busy_o && $stable(result_o)));
endmodule

bind gf_serial_mul gf_serial_mul_chk #(.N(N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .b_valid_i (b_valid_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/gf_serial_mul_test.sv
`timescale 1ns/1ps
module gf_serial_mul_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       valid = 1'b0;
  logic [5:0] a6 = '0;
  logic [5:0] mod6 = '0;
  logic [1:0] pair5 = '0;
  logic [1:0] pair6 = '0;
  logic       busy5, done5, busy6, done6;
  logic [4:0] res5;
  logic [5:0] res6;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gf_serial_mul #(.N(5)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a6[4:0]), .mod_i(mod6[4:0]),
    .b_valid_i(valid), .b_pair_i(pair5), .busy_o(busy5), .done_o(done5), .result_o(res5)
  );

  gf_serial_mul #(.N(6)) uut_six (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a6), .mod_i(mod6),
    .b_valid_i(valid), .b_pair_i(pair6), .busy_o(busy6), .done_o(done6), .result_o(res6)
  );

  function automatic int ref_mul(int a, int b, int f, int n);
    int p = 0;
    for (int i = 0; i < n; i++) if (((b >> i) & 1) != 0) p = p ^ (a << i);
    for (int d = 2 * n - 2; d >= n; d--)
      if (((p >> d) & 1) != 0) p = p ^ ((f | (1 << n)) << (d - n));
    return p;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(int a, int b, int f, bit stall, bit poke);
    int e5, e6;
    e5 = ref_mul(a & 31, b & 31, f & 31, 5);
    e6 = ref_mul(a, b, f, 6);
    @(negedge clk);
    start = 1'b1; a6 = 6'(a); mod6 = 6'(f); valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", {30'd0, busy5, busy6}, 3);
    for (int k = 0; k < 3; k++) begin
      if (stall && k == 1) begin
        valid = 1'b0; start = poke; a6 = ~6'(a); mod6 = ~6'(f);
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy held in stall", {30'd0, busy5, busy6}, 3);
      end
      valid = 1'b1;
      pair6 = {b[5-2*k], b[4-2*k]};
      if (k < 2) pair5 = {b[4-2*k], b[3-2*k]};
      else       pair5 = {b[0], ~a[0]};  // R5 pad slot driven with junk
      @(negedge clk);
      if (k < 2) chk("R4 busy before last pair", {30'd0, busy5, busy6}, 3);
    end
    valid = 1'b0;
    chk("R4 done/busy at end", {28'd0, done5, busy5, done6, busy6}, 4'b1010);
    chk("R3 product N=6", int'(res6), e6);
    chk("R5 product N=5 odd", int'(res5), e5);
    if (stall && poke) chk("R7 R9 start while busy ignored", int'(res6), e6);
    valid = 1'b1; pair5 = 2'b11; pair6 = 2'b11;  // R10 idle valid
    @(negedge clk);
    valid = 1'b0;
    chk("R6 done one cycle", {30'd0, done5, done6}, 0);
    chk("R10 idle stays idle", {30'd0, busy5, busy6}, 0);
    chk("R6 result held N=6", int'(res6), e6);
    chk("R6 result held N=5", int'(res5), e5);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int mods [3] = '{6'h03, 6'h2D, 6'h00};
    @(negedge clk);
    chk("R1 reset outputs", {20'd0, busy5, done5, res5, busy6, done6, res6}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {30'd0, busy5, busy6}, 0);
    // R9: field polynomial changes between operations
    for (int m = 0; m < 3; m++)
      for (int a = 0; a < 64; a++)
        for (int b = 0; b < 64; b++)
          run_op(a, b, mods[m], ((a ^ b) & 1) == 1, ((b >> 1) & 1) == 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule